// File: doc/BRIEF.md
# Masked-Address GPIO Port

This block is an eight-pin general-purpose I/O port that sits on an APB-style register bus. Each pin can be set as an input or as an output, and the port drives an output value and an output enable for every pad. Pad inputs are resynchronised into the bus clock domain before software can read them.

The data register is not at one address. It appears across a window of 256 word locations, and the word-address bits of each access form a per-pin mask. On a write, only the pins whose mask bit is set change, so software can update one pin, or any group of pins, in a single store without a read-modify-write. On a read, pins whose mask bit is clear read as zero. A separate direction register holds one bit per pin and is read and written as an ordinary byte.

The bus has no wait states and never reports an error. Addresses outside the data window and the direction register read as zero, and writes to them are dropped.

Top module: `mgpio_port`

## Requirements
- R1: After synchronous reset, the direction register and the output data register are both 0, so `pad_oe` and `pad_out` are 0 and every pin is an input.
- R2: A write to any word address 0x000 to 0x3FC (address bits [11:10] zero) uses address bits [9:2] as a mask, where mask bit n belongs to pin n. Pin n's output data bit takes `pwdata[n]` when its mask bit is 1 and keeps its old value when it is 0.
- R3: A read in the data window returns 0 in every bit position whose mask bit is 0, whatever the pin level.
- R4: A data-window read returns, for each bit with mask 1, the output data bit if the pin is an output and the synchronised pad level if the pin is an input.
- R5: The direction register is at word address 0x400. Bit n set to 1 makes pin n an output. It reads back exactly the byte that was last written, in `prdata[7:0]`, and `prdata[31:8]` is always 0.
- R6: `pad_oe` always equals the direction register. `pad_out` always equals the output data register, whichever way each pin points.
- R7: Reads from any other address return 0, and writes to them change neither the direction register nor the output data register.
- R8: `pready` is always 1 and `pslverr` is always 0.
- R9: A pad input change is visible to reads after exactly two rising clock edges. After the first edge the read still shows the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte address within the port |
| pwdata | input | 32 | Write data; bits [7:0] are used |
| prdata | output | 32 | Read data, valid while `psel` is high |
| pready | output | 1 | Transfer-done flag, tied high |
| pslverr | output | 1 | Error flag, tied low |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Output values to the pads |
| pad_oe | output | 8 | Per-pad output enable |

## Verification
The bench builds the port with its default parameters: eight pins, a 12-bit byte address, a 32-bit data bus and a two-stage input synchronizer. With these values the full 256-entry mask space can be reached through `paddr[9:2]`, the direction register sits at 0x400 right beside the top of the data window, and the two-edge pad latency can be measured one cycle at a time. Random masked writes, direction changes and pad changes are combined with masked reads, so every pin is seen as an input and as an output under masks that include it and masks that exclude it.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

    localparam int PIN_W        = 8;
    localparam int ADDR_W       = 12;
    localparam int BUS_W        = 32;
    localparam int SYNC_STAGES  = 2;
    localparam int DIR_WORD_ADR = 32'h100;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_DATA = 2'd1,
        RGN_DIR  = 2'd2
    } region_e;

    typedef struct packed {
        region_e           region;
        logic [PIN_W-1:0]  mask;
    } access_t;

    function automatic access_t decode_access(input logic [ADDR_W-1:0] addr);
        access_t acc;
        acc.mask = addr[PIN_W+1:2];
        if (addr[ADDR_W-1:PIN_W+2] == '0)
            acc.region = RGN_DATA;
        else if (addr[ADDR_W-1:2] == DIR_WORD_ADR[ADDR_W-3:0])
            acc.region = RGN_DIR;
        else
            acc.region = RGN_NONE;
        return acc;
    endfunction

    function automatic logic [PIN_W-1:0] merge_masked(
        input logic [PIN_W-1:0] old_v,
        input logic [PIN_W-1:0] new_v,
        input logic [PIN_W-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
    parameter int W      = mgpio_pkg::PIN_W,
    parameter int STAGES = mgpio_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
    import mgpio_pkg::*;
#(
    parameter int W = PIN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  region_e      region,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);
    logic wr_data;
    logic wr_dir;

    assign wr_data = wr_en && (region == RGN_DATA);
    assign wr_dir  = wr_en && (region == RGN_DIR);

    always_ff @(posedge clk) begin
        if (rst)          dir_q <= '0;
        else if (wr_dir)  dir_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)          out_q <= '0;
        else if (wr_data) out_q <= merge_masked(out_q, wdata, mask);
    end

    // R2: masked-off pins hold across a data write
    a_r2_masked_hold: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0));

    // R7: no register changes without a decoded write
    a_r7_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_data || wr_dir) |=> ($stable(out_q) && $stable(dir_q)));

endmodule

// File: rtl/mgpio_rdmux.sv
module mgpio_rdmux
    import mgpio_pkg::*;
#(
    parameter int W     = PIN_W,
    parameter int BUS_W_P = BUS_W
) (
    input  region_e          region,
    input  logic [W-1:0]     mask,
    input  logic [W-1:0]     dir_q,
    input  logic [W-1:0]     out_q,
    input  logic [W-1:0]     pin_sync,
    output logic [BUS_W_P-1:0] rdata
);
    logic [W-1:0] data_view;

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign data_view[i] = mask[i] & (dir_q[i] ? out_q[i] : pin_sync[i]);
    end

    always_comb begin
        rdata = '0;
        unique case (region)
            RGN_DATA: rdata[W-1:0] = data_view;
            RGN_DIR:  rdata[W-1:0] = dir_q;
            default:  rdata        = '0;
        endcase
    end

endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
    import mgpio_pkg::*;
#(
    parameter int NPINS   = PIN_W,
    parameter int AW      = ADDR_W,
    parameter int DW      = BUS_W,
    parameter int NSYNC   = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [DW-1:0]    pwdata,
    output logic [DW-1:0]    prdata,
    output logic             pready,
    output logic             pslverr,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    access_t          acc;
    logic             wr_en;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] pin_sync;
    logic [DW-1:0]    rd_word;

    assign acc   = decode_access(paddr);
    assign wr_en = psel && penable && pwrite;

    mgpio_sync #(.W(NPINS), .STAGES(NSYNC)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    mgpio_regs #(.W(NPINS)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .region (acc.region),
        .mask   (acc.mask),
        .wdata  (pwdata[NPINS-1:0]),
        .dir_q  (dir_q),
        .out_q  (out_q)
    );

    mgpio_rdmux #(.W(NPINS), .BUS_W_P(DW)) i_rdmux (
        .region   (acc.region),
        .mask     (acc.mask),
        .dir_q    (dir_q),
        .out_q    (out_q),
        .pin_sync (pin_sync),
        .rdata    (rd_word)
    );

    assign prdata  = psel ? rd_word : '0;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    // R3: masked-off bits read zero in the data window
    a_r3_masked_read_zero: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && paddr[AW-1:NPINS+2] == '0)
            |-> ((prdata[NPINS-1:0] & ~paddr[NPINS+1:2]) == '0));

    // R4: output pins read back their driven value
    a_r4_output_readback: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && paddr[AW-1:NPINS+2] == '0)
            |-> (((prdata[NPINS-1:0] ^ pad_out) & pad_oe & paddr[NPINS+1:2]) == '0));

    // R5: upper read bits are always zero
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        psel |-> (prdata[DW-1:NPINS] == '0));

endmodule

// File: tb/test_mgpio_port.sv
module test_mgpio_port;
    localparam int CLK_HALF = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int total = 0;
    int bad = 0;
    logic [7:0] m_dir = '0;
    logic [7:0] m_out = '0;

    always #CLK_HALF clk = ~clk;

    mgpio_port i_mgpio_port (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] mask);
        return mask & ((m_dir & m_out) | (~m_dir & pad_in));
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        if (a[11:10] == 2'b00)
            m_out = (m_out & ~a[9:2]) | (d[7:0] & a[9:2]);
        else if (a[11:2] == 10'h100)
            m_dir = d[7:0];
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        check({31'd0, pready}, 32'd1, "R8 pready");
        check({31'd0, pslverr}, 32'd0, "R8 pslverr");
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic set_pad(input logic [7:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [11:0] data_addr(input logic [7:0] mask);
        return {2'b00, mask, 2'b00};
    endfunction

    initial begin
        #(2 * CLK_HALF * 200000);
        bad++; total++;
        $display("FAIL watchdog: got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  old_pad;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check({24'd0, pad_oe}, 32'd0, "R1 pad_oe");
        check({24'd0, pad_out}, 32'd0, "R1 pad_out");
        bus_read(12'h400, rd); check(rd, 32'd0, "R1 dir reads 0");
        bus_read(data_addr(8'hFF), rd); check(rd, 32'd0, "R1 data reads 0");

        // R2: masked write
        bus_write(data_addr(8'hFF), 32'hFFFF_FFA5);
        check({24'd0, pad_out}, 32'hA5, "R2 full-mask write");
        bus_write(data_addr(8'h0F), 32'h0000_0050);
        check({24'd0, pad_out}, 32'hA0, "R2 partial-mask write");
        bus_write(data_addr(8'h00), 32'h0000_00FF);
        check({24'd0, pad_out}, 32'hA0, "R2 zero-mask write");

        // R6: output enable follows direction, pad_out independent of it
        bus_write(12'h400, 32'h0000_003C);
        check({24'd0, pad_oe}, 32'h3C, "R6 pad_oe");
        check({24'd0, pad_out}, 32'hA0, "R6 pad_out");

        // R4: mixed input/output read
        set_pad(8'h96);
        bus_read(data_addr(8'hFF), rd); check(rd, 32'h0000_00A2, "R4 mixed read");

        // R3: masked read
        bus_read(data_addr(8'h0F), rd); check(rd, 32'h0000_0002, "R3 masked read");
        bus_read(data_addr(8'h00), rd); check(rd, 32'h0, "R3 zero-mask read");

        // R5: direction readback and upper bits
        bus_read(12'h400, rd); check(rd, 32'h0000_003C, "R5 dir readback");

        // R7: unmapped addresses
        bus_write(12'h404, 32'h0000_00FF);
        bus_write(12'h800, 32'h0000_00FF);
        bus_write(12'hFFC, 32'h0000_0000);
        bus_read(12'h404, rd); check(rd, 32'h0, "R7 unmapped 0x404");
        bus_read(12'h800, rd); check(rd, 32'h0, "R7 unmapped 0x800");
        check({24'd0, pad_oe}, 32'h3C, "R7 dir untouched");
        check({24'd0, pad_out}, 32'hA0, "R7 data untouched");

        // R9: two-edge synchronizer latency
        bus_write(12'h400, 32'h0);
        @(negedge clk);
        old_pad = pad_in;
        psel = 1'b1; pwrite = 1'b0; paddr = data_addr(8'hFF);
        pad_in = 8'h5A;
        @(negedge clk);
        check(prdata, {24'd0, old_pad}, "R9 after one edge");
        @(negedge clk);
        check(prdata, 32'h0000_005A, "R9 after two edges");
        psel = 1'b0;

        // random mix, R2 R3 R4 R5 R7
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [7:0] mk;
            op = int'($urandom_range(0, 5));
            mk = 8'($urandom);
            case (op)
                0: bus_write(data_addr(mk), $urandom);
                1: bus_write(12'h400, $urandom);
                2: set_pad(8'($urandom));
                3: begin
                    bus_read(data_addr(mk), rd);
                    check(rd, {24'd0, exp_read(mk)}, "R4 random data read");
                end
                4: begin
                    bus_read(12'h400, rd);
                    check(rd, {24'd0, m_dir}, "R5 random dir read");
                end
                default: begin
                    bus_write({2'b01, 8'($urandom), 2'b00} | 12'h004, $urandom);
                    check({24'd0, pad_out}, {24'd0, m_out}, "R7 random unmapped write");
                    check({24'd0, pad_oe}, {24'd0, m_dir}, "R6 random oe");
                end
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule